// File: doc/BRIEF.md
# Guarded-Reload Watchdog Timer

This block is a watchdog that forces a system reset when software stops servicing it. The clock is first divided by a fixed ratio and then by a binary prescaler. Together they produce a slow tick, which is about 2 ms with the default parameters and a 12 MHz oscillator. An up-counter advances once per tick. When it rolls over from its maximum value, the block emits a reset pulse. Software services the watchdog by writing a new start value to the counter. The time left before reset is therefore (2^CNT_W − value) ticks.

A write is honoured only when an arming flag has been set beforehand by a separate strobe. The flag drops by itself when the load happens, so a runaway program that loops over one store instruction cannot keep the watchdog alive. While the enable input is high, the block also tells the power manager that power-down is forbidden. The idle indication does not slow or stop the watchdog.

Top module: `wdg_guarded_reload`

## Requirements
- R1: With enable high, a value V loaded at clock edge E makes the reset output rise right after edge E + (2^CNT_W − V) × T, where T = DIV_FIXED × 2^PRESC_W. With the defaults, V = 8'hFF gives one tick and V = 8'h00 gives 256 ticks.
- R2: While enabled, the counter advances exactly once per T clock cycles, measured from the last load or the last re-enable.
- R3: On overflow the reset output stays high for exactly PULSE_LEN cycles. At the same edge the counter restarts from 0 and the arming flag is cleared, so the next timeout takes a full 2^CNT_W ticks.
- R4: A register write while the arming flag is low is ignored. The pending timeout is unchanged.
- R5: A write while the flag is high loads the counter, clears the flag on the same edge and restarts the prescaler chain from zero.
- R6: If the arming strobe and a register write are sampled on the same edge, the write is rejected and the flag ends up set.
- R7: With enable low, the counter and prescaler chain do not advance and no reset is produced. The power-down block output equals the enable input.
- R8: The idle input has no effect. Timeouts are identical with idle high or low.
- R9: While the synchronous active-low reset is sampled low, the counter, prescaler chain, flag and reset output all go to zero.
- R10: If an accepted write and a tick fall on the same edge, the load wins and no overflow is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | CNT_W | Reload value |
| wd_en_i | input | 1 | Watchdog enable |
| idle_i | input | 1 | CPU idle indication (no effect on counting) |
| arm_set_i | input | 1 | Strobe that sets the arming flag |
| sys_rst_o | output | 1 | System reset pulse |
| arm_flag_o | output | 1 | Current arming flag |
| pd_block_o | output | 1 | High when power-down is forbidden |

## Verification
The arming flag changes one cycle after the edge that samples the set strobe or the accepted write. The power-down block output follows the enable input in the same cycle. The reset output rises exactly (2^CNT_W − V) × T cycles after the edge that samples the accepted write, and it stays high for PULSE_LEN cycles. The bench drives inputs on falling edges and samples on the next falling edge, after the register update. Each timeout is measured as a cycle difference from the load edge. A behavioural model steps on each rising edge and is compared with all outputs on every falling edge.

// File: rtl/wdg_pkg.sv
// Package: shared constants and types for the guarded-reload watchdog.
// Assumes: the counter width is fixed by the application at 8 bits by default.
package wdg_pkg;
    localparam int unsigned WDG_CNT_W_DEF   = 8;
    localparam int unsigned WDG_DIV_DEF     = 12;
    localparam int unsigned WDG_PRESC_W_DEF = 11;
    localparam int unsigned WDG_PULSE_DEF   = 4;

    // Next action on the arming flag, in priority order.
    typedef enum logic [1:0] {
        ARM_KEEP  = 2'd0,
        ARM_RAISE = 2'd1,
        ARM_DROP  = 2'd2
    } arm_op_e;
endpackage

// File: rtl/wdg_tick_gen.sv
// Module: wdg_tick_gen
// Divides the clock by DIV (generate picks a bypass for DIV == 1), then by a
// PRESC_W-bit prescaler, and emits a one-cycle tick on each prescaler rollover.
// Assumes: clr_i is a one-cycle strobe from an accepted load. While en_i is
// low the whole chain is held at zero.
module wdg_tick_gen #(
    parameter int unsigned DIV     = 12,
    parameter int unsigned PRESC_W = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic clr_i,
    input  logic idle_i,
    output logic tick_o
);
    localparam int unsigned DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic               stroke;
    logic [PRESC_W-1:0] pre_q;

    generate
        if (DIV > 1) begin : g_div
            logic [DIV_W-1:0] div_q;
            // Fixed-ratio divider: counts 0..DIV-1 while enabled.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_i || !en_i)
                    div_q <= '0;
                else if (div_q == DIV_W'(DIV - 1))
                    div_q <= '0;
                else
                    div_q <= div_q + 1'b1;
            end
            assign stroke = en_i && (div_q == DIV_W'(DIV - 1));
        end else begin : g_nodiv
            assign stroke = en_i;
        end
    endgenerate

    // Prescaler: advances once per divider stroke.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || !en_i)
            pre_q <= '0;
        else if (stroke)
            pre_q <= pre_q + 1'b1;
    end

    assign tick_o = stroke && (&pre_q);

    assert_tick_wraps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (pre_q == '0));
    assert_chain_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (pre_q == '0) && !tick_o);
    assert_idle_runs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_i && en_i && !clr_i && !tick_o) |=>
            ((pre_q == $past(pre_q)) || (pre_q == $past(pre_q) + 1'b1)));
endmodule

// File: rtl/wdg_arm_ctrl.sv
// Module: wdg_arm_ctrl
// Holds the arming flag and decides whether a register write is a load.
// Assumes: ovf_i is the one-cycle overflow strobe from the counter core.
// Priority on the flag: overflow drop > set strobe > load drop.
module wdg_arm_ctrl
    import wdg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wr_i,
    input  logic ovf_i,
    output logic flag_o,
    output logic load_o
);
    logic    flag_q;
    arm_op_e op;

    assign load_o = wr_i && flag_q && !set_i;

    // Select the flag action for this cycle.
    always_comb begin
        if (ovf_i)       op = ARM_DROP;
        else if (set_i)  op = ARM_RAISE;
        else if (load_o) op = ARM_DROP;
        else             op = ARM_KEEP;
    end

    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)                flag_q <= 1'b0;
        else if (op == ARM_RAISE)  flag_q <= 1'b1;
        else if (op == ARM_DROP)   flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    assert_flag_clears_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !flag_o);
    assert_collision_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && wr_i && !ovf_i) |=> flag_o);
    assert_ovf_drops_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_i |=> !flag_o);
endmodule

// File: rtl/wdg_count_core.sv
// Module: wdg_count_core
// CNT_W-bit up-counter advanced by tick_i and loaded by load_i (the load wins).
// A tick at the maximum value is an overflow. It restarts the count from zero
// and stretches the reset output to PULSE_LEN cycles.
module wdg_count_core #(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned PULSE_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    input  logic             tick_i,
    output logic             ovf_o,
    output logic             sys_rst_o
);
    localparam int unsigned PL_W = $clog2(PULSE_LEN + 1);

    logic [CNT_W-1:0] count_q;
    logic [PL_W-1:0]  pulse_q;

    assign ovf_o = tick_i && !load_i && (&count_q);

    // Counter: load, advance on tick, wrap to zero on overflow.
    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (load_i) count_q <= val_i;
        else if (tick_i) count_q <= count_q + 1'b1;
    end

    // Reset pulse stretcher.
    always_ff @(posedge clk) begin
        if (!rst_n)             pulse_q <= '0;
        else if (ovf_o)         pulse_q <= PL_W'(PULSE_LEN);
        else if (pulse_q != '0) pulse_q <= pulse_q - 1'b1;
    end

    assign sys_rst_o = (pulse_q != '0);

    assert_pulse_after_ovf_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> sys_rst_o);
    assert_hold_without_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !tick_i) |=> (count_q == $past(count_q)));
    assert_load_beats_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && tick_i) |=> (count_q == $past(val_i)) && !ovf_o);
    assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (count_q == '0));
endmodule

// File: rtl/wdg_guarded_reload.sv
// Module: wdg_guarded_reload (top)
// Watchdog with an armed reload. It ties the tick chain, the arming control and
// the counter core together, and reports the power-down block.
// Assumes: all inputs are synchronous to clk; rst_n is synchronous active-low.
module wdg_guarded_reload
    import wdg_pkg::*;
#(
    parameter int unsigned CNT_W     = WDG_CNT_W_DEF,
    parameter int unsigned DIV_FIXED = WDG_DIV_DEF,
    parameter int unsigned PRESC_W   = WDG_PRESC_W_DEF,
    parameter int unsigned PULSE_LEN = WDG_PULSE_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_i,
    input  logic [CNT_W-1:0] reg_wdata_i,
    input  logic             wd_en_i,
    input  logic             idle_i,
    input  logic             arm_set_i,
    output logic             sys_rst_o,
    output logic             arm_flag_o,
    output logic             pd_block_o
);
    logic load;
    logic tick;
    logic ovf;

    wdg_tick_gen #(.DIV(DIV_FIXED), .PRESC_W(PRESC_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en_i(wd_en_i), .clr_i(load),
        .idle_i(idle_i), .tick_o(tick)
    );

    wdg_arm_ctrl u_arm (
        .clk(clk), .rst_n(rst_n), .set_i(arm_set_i), .wr_i(reg_wr_i),
        .ovf_i(ovf), .flag_o(arm_flag_o), .load_o(load)
    );

    wdg_count_core #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_core (
        .clk(clk), .rst_n(rst_n), .load_i(load), .val_i(reg_wdata_i),
        .tick_i(tick), .ovf_o(ovf), .sys_rst_o(sys_rst_o)
    );

    assign pd_block_o = wd_en_i;

    assert_no_ovf_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_en_i |-> !ovf);
    assert_rejected_write_keeps_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && !arm_flag_o && !arm_set_i) |=> !arm_flag_o);
endmodule

// File: tb/sim_wdg_guarded_reload.sv
module sim_wdg_guarded_reload;
    localparam int DIV = 3;
    localparam int PW  = 2;
    localparam int PL  = 3;
    localparam int T   = DIV * (1 << PW);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic en = 1'b0;
    logic idle = 1'b0;
    logic arm = 1'b0;
    logic srst, flag, pdb;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int m_phase = 0, m_count = 0, m_left = 0;
    bit m_flag = 0;
    bit done = 0;

    always #10 clk = ~clk;

    wdg_guarded_reload #(.CNT_W(8), .DIV_FIXED(DIV), .PRESC_W(PW), .PULSE_LEN(PL)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .wd_en_i(en), .idle_i(idle), .arm_set_i(arm),
        .sys_rst_o(srst), .arm_flag_o(flag), .pd_block_o(pdb)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Behavioural reference: one phase counter standing in for the tick chain.
    always @(posedge clk) begin
        bit tk, ld, ov;
        cyc++;
        if (!rst_n) begin
            m_phase = 0; m_count = 0; m_left = 0; m_flag = 0;
        end else begin
            tk = en && (m_phase == T - 1);
            ld = wr && m_flag && !arm;
            ov = tk && !ld && (m_count == 255);
            m_phase = (ld || !en) ? 0 : (m_phase + 1) % T;
            m_count = ld ? int'(wdata) : (tk ? (m_count + 1) % 256 : m_count);
            m_left = ov ? PL : (m_left > 0 ? m_left - 1 : 0);
            m_flag = ov ? 1'b0 : (arm ? 1'b1 : (ld ? 1'b0 : m_flag));
        end
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (cyc > 0) begin
            check("R1/R3 model reset output", int'(srst), (m_left > 0) ? 1 : 0);
            check("R4/R5/R6 model flag", int'(flag), int'(m_flag));
            check("R7 model power-down block", int'(pdb), int'(en));
        end
    end

    task automatic load(input logic [7:0] v, output int lcyc);
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0; wr = 1'b1; wdata = v;
        @(negedge clk); wr = 1'b0;
        lcyc = cyc;
    endtask

    task automatic wait_rise(input int start, input int exp, input string req);
        int n = 0;
        while (!srst && n < exp + 40) begin
            @(negedge clk); n++;
        end
        check(req, cyc - start, exp);
    endtask

    initial begin
        int l, w;
        repeat (3) @(negedge clk);
        check("R9 reset output low in reset", int'(srst), 0);
        check("R9 flag low in reset", int'(flag), 0);
        rst_n = 1'b1; en = 1'b1;

        // R1: shortest timeout, then pulse length and post-overflow state (R3).
        load(8'hFF, l);
        check("R5 flag cleared by load", int'(flag), 0);
        wait_rise(l, 1 * T, "R1 timeout FF");
        w = 0;
        while (srst) begin @(negedge clk); w++; end
        check("R3 pulse length", w, PL);
        check("R3 flag cleared after overflow", int'(flag), 0);

        // R4: unarmed write must not shorten the timeout.
        load(8'hF0, l);
        @(negedge clk); wr = 1'b1; wdata = 8'hFF;
        @(negedge clk); wr = 1'b0;
        check("R4 unarmed write leaves flag low", int'(flag), 0);
        wait_rise(l, 16 * T, "R4 unarmed write ignored");
        while (srst) @(negedge clk);

        // R6: strobe and write together are rejected, flag ends set.
        load(8'hF0, l);
        @(negedge clk); arm = 1'b1; wr = 1'b1; wdata = 8'hFF;
        @(negedge clk); arm = 1'b0; wr = 1'b0;
        check("R6 flag set after collision", int'(flag), 1);
        repeat (2 * T) @(negedge clk);
        check("R6 collision write not loaded", int'(srst), 0);
        @(negedge clk); wr = 1'b1; wdata = 8'hF0;
        @(negedge clk); wr = 1'b0; l = cyc;
        check("R5 armed write accepted", int'(flag), 0);
        wait_rise(l, 16 * T, "R5 reload restarts timeout");
        while (srst) @(negedge clk);

        // R7: disabled watchdog never fires.
        load(8'hFF, l);
        en = 1'b0;
        w = 0;
        repeat (400) begin @(negedge clk); if (srst) w++; end
        check("R7 no reset while disabled", w, 0);
        check("R7 power-down allowed when off", int'(pdb), 0);
        en = 1'b1; l = cyc;
        wait_rise(l, T, "R7/R2 resume after re-enable");
        while (srst) @(negedge clk);

        // R8: idle does not change the timeout.
        idle = 1'b1;
        load(8'hF0, l);
        wait_rise(l, 16 * T, "R8 timeout with idle high");
        idle = 1'b0;
        while (srst) @(negedge clk);

        // R10: reload lands on the overflow tick edge.
        load(8'hFF, l);
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
        while (cyc < l + T - 1) @(negedge clk);
        wr = 1'b1; wdata = 8'hFF;
        @(negedge clk); wr = 1'b0;
        check("R10 no reset on colliding tick", int'(srst), 0);
        wait_rise(l + T, T, "R10 load wins over tick");
        while (srst) @(negedge clk);

        // R1/R2: longest timeout.
        load(8'h00, l);
        wait_rise(l, 256 * T, "R1 timeout 00");
        while (srst) @(negedge clk);

        // R9: mid-run reset clears everything.
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R9 flag cleared by reset", int'(flag), 0);
        rst_n = 1'b1; l = cyc;
        wait_rise(l, 256 * T, "R9 counter zero after reset");
        repeat (PL + 2) @(negedge clk);
        finish_run();
    end
endmodule